// File: doc/BRIEF.md
# Word-Granular Write-Back Cache Controller

This block is a small direct-mapped data cache for one thread's private copy of shared memory. The thread issues word reads and writes. Writes stay in the cache and mark the word as modified. Reads are served from the cache when the word is present and are fetched from main memory otherwise. Every word of a line has its own valid bit and its own modified bit. A line can therefore be fully invalid, clean, dirty, clean mixed with dirty, or invalid mixed with dirty. Words the thread never wrote are never pushed back to memory.

The same request channel carries four consistency commands. Flush pushes out every modified word and then empties the cache. Release pushes out modified words and keeps them resident as clean. Acquire drops clean words and keeps modified ones. Barrier does both: modified words are written back and stay resident as clean, and words that were already clean are dropped. When a new address conflicts with a resident line, the controller evicts that line by writing back only its modified words.

The memory side has a word read port that answers in the same cycle and a word write port that takes one word per beat.

Top module: `cwb_cache_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, mem_rd_en and mem_wr_en are 0, and every word is invalid, so the first read of any address fetches from memory.
- R2: A write (req_op 1) updates only the cached word and marks it modified. No memory write beat is issued for it at that time.
- R3: A read (req_op 0) of a resident word raises rsp_valid with the cached value in the cycle after acceptance, with no memory beat.
- R4: A read of an absent word fills its line from memory, one beat per word that is not modified. Modified words in that line keep their local values. The address is {tag, index, offset} with the offset in the low bits.
- R5: A flush (req_op 2) writes back each modified word of the whole cache at its own word address, then leaves every word invalid.
- R6: An acquire (req_op 3) takes one cycle with no memory traffic. It invalidates clean words and keeps modified words resident.
- R7: A release (req_op 4) writes back modified words and keeps them resident and clean. Later reads of them hit, and a later flush writes nothing for them.
- R8: A barrier (req_op 5) writes back modified words and keeps them resident and clean, and invalidates words that were already clean.
- R9: An access whose tag differs from a resident line evicts that line by writing back only its modified words at the old line address. An evicted line with no modified words costs no write beats.
- R10: req_ready is low while eviction, fill, flush, release or barrier beats are in progress and during the finishing cycle that follows eviction or fill.
- R11: The controller never issues a memory read beat and a memory write beat in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 3 | 0 read, 1 write, 2 flush, 3 acquire, 4 release, 5 barrier |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | DW | Read data |
| mem_rd_en | output | 1 | Memory read beat |
| mem_rd_addr | output | AW | Memory read word address |
| mem_rd_data | input | DW | Memory read data, valid in the same cycle |
| mem_wr_en | output | 1 | Memory write beat |
| mem_wr_addr | output | AW | Memory write word address |
| mem_wr_data | output | DW | Memory write data |

## Verification
The assertions assume a few things about the inputs. Memory returns read data in the same cycle as the read beat. req_op carries only the six defined codes. A request holds its fields steady until it is accepted. The stimulus follows these rules. It drives requests on the falling edge and holds them until req_ready is seen high. It never sends a new request while a read response is pending. Its memory model answers reads combinationally from an array loaded during reset.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_FLUSH   = 3'd2,
        OP_ACQUIRE = 3'd3,
        OP_RELEASE = 3'd4,
        OP_BARRIER = 3'd5
    } cwb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WALK,
        ST_DONE
    } cwb_state_e;

    typedef enum logic [2:0] {
        LC_INVALID,
        LC_CLEAN,
        LC_DIRTY,
        LC_CLEAN_DIRTY,
        LC_INVALID_DIRTY
    } line_class_e;

    // Line class from which kinds of words are present in it
    function automatic line_class_e classify(input logic has_inv,
                                             input logic has_cln,
                                             input logic has_drt);
        line_class_e c;
        if (!has_drt)      c = has_cln ? LC_CLEAN : LC_INVALID;
        else if (has_cln)  c = LC_CLEAN_DIRTY;
        else if (has_inv)  c = LC_INVALID_DIRTY;
        else               c = LC_DIRTY;
        return c;
    endfunction

endpackage

// File: rtl/cwb_step_ctr.sv
module cwb_step_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] lim,
    output logic [CW-1:0] cnt,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign last = (cnt_q == lim);
    assign cnt  = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (inc)  cnt_d = last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Beat index stays inside the active sequence (R5)
    assert_ctr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !clr |=> cnt_q <= $past(lim));

endmodule

// File: rtl/cwb_line_store.sv
module cwb_line_store #(
    parameter int LINES = 4,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    parameter int TW    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic [TW-1:0]         rd_tag,
    output logic [WORDS-1:0]      rd_valid,
    output logic [WORDS-1:0]      rd_dirty,
    output logic [WORDS*DW-1:0]   rd_data,
    input  logic                  upd_en,
    input  logic [$clog2(LINES)-1:0] upd_idx,
    input  logic [TW-1:0]         upd_tag,
    input  logic [WORDS-1:0]      upd_valid,
    input  logic [WORDS-1:0]      upd_dirty,
    input  logic [WORDS-1:0]      dat_we,
    input  logic [DW-1:0]         dat_wdata,
    input  logic                  acq_all
);
    import cwb_pkg::*;

    localparam int IW = $clog2(LINES);

    typedef struct packed {
        logic [TW-1:0]    tag;
        logic [WORDS-1:0] val;
        logic [WORDS-1:0] dirty;
    } meta_t;

    meta_t         meta_d [LINES];
    meta_t         meta_q [LINES];
    logic [DW-1:0] data_q [LINES][WORDS];

    assign rd_tag   = meta_q[rd_idx].tag;
    assign rd_valid = meta_q[rd_idx].val;
    assign rd_dirty = meta_q[rd_idx].dirty;

    for (genvar w = 0; w < WORDS; w++) begin : g_rd
        assign rd_data[w*DW +: DW] = data_q[rd_idx][w];
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic        sel;
        line_class_e cls;

        assign sel = upd_en && (upd_idx == IW'(g));
        assign cls = classify(|(~meta_q[g].val),
                              |(meta_q[g].val & ~meta_q[g].dirty),
                              |meta_q[g].dirty);

        always_comb begin
            meta_d[g] = meta_q[g];
            if (sel) begin
                meta_d[g].tag   = upd_tag;
                meta_d[g].val   = upd_valid;
                meta_d[g].dirty = upd_dirty;
            end else if (acq_all) begin
                meta_d[g].val = meta_q[g].dirty;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) meta_q[g] <= '0;
            else        meta_q[g] <= meta_d[g];
        end

        for (genvar w = 0; w < WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (sel && dat_we[w]) data_q[g][w] <= dat_wdata;
            end
        end

        // A modified word is always resident (R2)
        assert_dirty_has_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (meta_q[g].dirty & ~meta_q[g].val) == '0);

        // After acquire no line holds clean words (R6)
        assert_acquire_drops_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
            acq_all && !sel |=> (cls != LC_CLEAN) && (cls != LC_CLEAN_DIRTY));

        // Acquire leaves modified words untouched (R6)
        assert_acquire_keeps_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
            acq_all && !sel |=> meta_q[g].dirty == $past(meta_q[g].dirty));
    end

endmodule

// File: rtl/cwb_cache_ctrl.sv
module cwb_cache_ctrl #(
    parameter int AW         = 10,
    parameter int DW         = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data
);
    import cwb_pkg::*;

    localparam int OW = $clog2(LINE_WORDS);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW - OW;
    localparam int NW = LINES * LINE_WORDS;
    localparam int CW = $clog2(NW);

    typedef struct packed {
        cwb_state_e    state;
        cwb_op_e       op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          rsp_valid;
        logic [DW-1:0] rsp_data;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    // Storage interface
    logic [IW-1:0]            rd_idx;
    logic [TW-1:0]            rd_tag;
    logic [LINE_WORDS-1:0]    rd_valid, rd_dirty;
    logic [LINE_WORDS*DW-1:0] rd_data;
    logic [DW-1:0]            rd_word [LINE_WORDS];
    logic                     upd_en;
    logic [TW-1:0]            upd_tag;
    logic [LINE_WORDS-1:0]    upd_valid, upd_dirty, dat_we;
    logic [DW-1:0]            dat_wdata;
    logic                     acq_all;

    // Beat counter
    logic          ctr_clr, ctr_inc, ctr_last;
    logic [CW-1:0] ctr_lim, cnt;

    // Address fields
    logic [AW-1:0]         cur_addr;
    logic [TW-1:0]         cur_tag;
    logic [IW-1:0]         cur_idx;
    logic [OW-1:0]         cur_off;
    logic [OW-1:0]         beat_w;
    logic [IW-1:0]         walk_line;
    logic [LINE_WORDS-1:0] off_mask, beat_mask;
    logic                  tag_hit, any_dirty;
    cwb_op_e               in_op;

    cwb_line_store #(
        .LINES (LINES),
        .WORDS (LINE_WORDS),
        .DW    (DW),
        .TW    (TW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx),
        .rd_tag    (rd_tag),
        .rd_valid  (rd_valid),
        .rd_dirty  (rd_dirty),
        .rd_data   (rd_data),
        .upd_en    (upd_en),
        .upd_idx   (rd_idx),
        .upd_tag   (upd_tag),
        .upd_valid (upd_valid),
        .upd_dirty (upd_dirty),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .acq_all   (acq_all)
    );

    cwb_step_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .lim   (ctr_lim),
        .cnt   (cnt),
        .last  (ctr_last)
    );

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        assign rd_word[w] = rd_data[w*DW +: DW];
    end

    assign in_op     = cwb_op_e'(req_op);
    assign cur_addr  = (ctrl_q.state == ST_IDLE) ? req_addr : ctrl_q.addr;
    assign cur_tag   = cur_addr[AW-1:IW+OW];
    assign cur_idx   = cur_addr[IW+OW-1:OW];
    assign cur_off   = cur_addr[OW-1:0];
    assign beat_w    = cnt[OW-1:0];
    assign walk_line = cnt[CW-1:OW];
    assign rd_idx    = (ctrl_q.state == ST_WALK) ? walk_line : cur_idx;
    assign off_mask  = LINE_WORDS'(1) << cur_off;
    assign beat_mask = LINE_WORDS'(1) << beat_w;
    assign tag_hit   = (rd_tag == cur_tag);
    assign any_dirty = |rd_dirty;
    assign ctr_lim   = (ctrl_q.state == ST_WALK) ? CW'(NW - 1) : CW'(LINE_WORDS - 1);

    assign req_ready = (ctrl_q.state == ST_IDLE);
    assign rsp_valid = ctrl_q.rsp_valid;
    assign rsp_rdata = ctrl_q.rsp_data;

    always_comb begin
        ctrl_d           = ctrl_q;
        ctrl_d.rsp_valid = 1'b0;
        upd_en           = 1'b0;
        upd_tag          = rd_tag;
        upd_valid        = rd_valid;
        upd_dirty        = rd_dirty;
        dat_we           = '0;
        dat_wdata        = ctrl_q.wdata;
        acq_all          = 1'b0;
        ctr_clr          = 1'b0;
        ctr_inc          = 1'b0;
        mem_rd_en        = 1'b0;
        mem_rd_addr      = '0;
        mem_wr_en        = 1'b0;
        mem_wr_addr      = '0;
        mem_wr_data      = '0;

        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.op    = in_op;
                    ctrl_d.addr  = req_addr;
                    ctrl_d.wdata = req_wdata;
                    ctr_clr      = 1'b1;
                    case (in_op)
                        OP_READ: begin
                            if (tag_hit && rd_valid[cur_off]) begin
                                ctrl_d.rsp_valid = 1'b1;
                                ctrl_d.rsp_data  = rd_word[cur_off];
                            end else if (tag_hit) begin
                                ctrl_d.state = ST_FILL;
                            end else if (any_dirty) begin
                                ctrl_d.state = ST_EVICT;
                            end else begin
                                upd_en       = 1'b1;
                                upd_tag      = cur_tag;
                                upd_valid    = '0;
                                upd_dirty    = '0;
                                ctrl_d.state = ST_FILL;
                            end
                        end
                        OP_WRITE: begin
                            if (tag_hit || !any_dirty) begin
                                upd_en    = 1'b1;
                                upd_tag   = cur_tag;
                                upd_valid = (tag_hit ? rd_valid : '0) | off_mask;
                                upd_dirty = (tag_hit ? rd_dirty : '0) | off_mask;
                                dat_we    = off_mask;
                                dat_wdata = req_wdata;
                            end else begin
                                ctrl_d.state = ST_EVICT;
                            end
                        end
                        OP_FLUSH, OP_RELEASE, OP_BARRIER: ctrl_d.state = ST_WALK;
                        OP_ACQUIRE: acq_all = 1'b1;
                        default: ;
                    endcase
                end
            end

            ST_EVICT: begin
                if (rd_dirty[beat_w]) begin
                    mem_wr_en   = 1'b1;
                    mem_wr_addr = {rd_tag, cur_idx, beat_w};
                    mem_wr_data = rd_word[beat_w];
                end
                ctr_inc = 1'b1;
                if (ctr_last) begin
                    upd_en       = 1'b1;
                    upd_tag      = cur_tag;
                    upd_valid    = '0;
                    upd_dirty    = '0;
                    ctr_clr      = 1'b1;
                    ctrl_d.state = (ctrl_q.op == OP_READ) ? ST_FILL : ST_DONE;
                end
            end

            ST_FILL: begin
                if (!rd_dirty[beat_w]) begin
                    mem_rd_en   = 1'b1;
                    mem_rd_addr = {cur_tag, cur_idx, beat_w};
                    upd_en      = 1'b1;
                    upd_tag     = cur_tag;
                    upd_valid   = rd_valid | beat_mask;
                    dat_we      = beat_mask;
                    dat_wdata   = mem_rd_data;
                end
                ctr_inc = 1'b1;
                if (ctr_last) ctrl_d.state = ST_DONE;
            end

            ST_DONE: begin
                if (ctrl_q.op == OP_READ) begin
                    ctrl_d.rsp_valid = 1'b1;
                    ctrl_d.rsp_data  = rd_word[cur_off];
                end else begin
                    upd_en    = 1'b1;
                    upd_tag   = cur_tag;
                    upd_valid = rd_valid | off_mask;
                    upd_dirty = rd_dirty | off_mask;
                    dat_we    = off_mask;
                end
                ctrl_d.state = ST_IDLE;
            end

            ST_WALK: begin
                if (rd_dirty[beat_w]) begin
                    mem_wr_en   = 1'b1;
                    mem_wr_addr = {rd_tag, walk_line, beat_w};
                    mem_wr_data = rd_word[beat_w];
                end
                upd_en = 1'b1;
                case (ctrl_q.op)
                    OP_FLUSH: begin
                        upd_valid = rd_valid & ~beat_mask;
                        upd_dirty = rd_dirty & ~beat_mask;
                    end
                    OP_BARRIER: begin
                        upd_valid = (rd_valid & ~beat_mask) | (rd_dirty & beat_mask);
                        upd_dirty = rd_dirty & ~beat_mask;
                    end
                    default: upd_dirty = rd_dirty & ~beat_mask;
                endcase
                ctr_inc = 1'b1;
                if (ctr_last) ctrl_d.state = ST_IDLE;
            end

            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            ctrl_q.state <= ST_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // Memory read and write beats never coincide (R11)
    assert_no_mem_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // No request is accepted while beats are in flight (R10)
    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> !req_ready);

    // Fill beats stay inside the requested line (R4)
    assert_fill_in_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> mem_rd_addr[AW-1:OW] == ctrl_q.addr[AW-1:OW]);

    // A write beat is followed by more beats or a return to idle, never a response (R5)
    assert_wr_no_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en && ctrl_q.op != OP_READ |=> !rsp_valid);

endmodule

// File: tb/tb_cwb_cache_ctrl.sv
module tb_cwb_cache_ctrl;
    import cwb_pkg::*;

    localparam int AW = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [DW-1:0] mem_rd_data, mem_wr_data;

    logic [DW-1:0] mem [1 << AW];
    int rd_beats = 0;
    int wr_beats = 0;
    int overlap  = 0;
    int checks   = 0;
    int errors   = 0;
    logic busy_after = 1'b0;

    always #10 clk = ~clk;

    cwb_cache_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data)
    );

    function automatic logic [DW-1:0] memval(input int a);
        return 32'hA500_0000 | DW'(a);
    endfunction

    assign mem_rd_data = mem[mem_rd_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) mem[i] <= memval(i);
        end else begin
            if (mem_wr_en) begin
                mem[mem_wr_addr] <= mem_wr_data;
                wr_beats <= wr_beats + 1;
            end
            if (mem_rd_en) rd_beats <= rd_beats + 1;
            if (mem_rd_en && mem_wr_en) overlap <= overlap + 1;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd,
                         output logic [DW-1:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid  = 1'b0;
        busy_after = !req_ready;
        lat = 1;
        rd  = '0;
        if (op == OP_READ) begin
            while (!rsp_valid && lat < 200) begin
                @(negedge clk);
                lat++;
            end
            rd = rsp_rdata;
        end
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        logic [DW-1:0] d;
        int l;
        issue(op, a, wd, d, l);
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat);
        issue(OP_READ, a, '0, d, lat);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 mem beats", 32'({mem_rd_en, mem_wr_en}), 32'd0);
    endtask

    task automatic t_read_write;
        logic [DW-1:0] d;
        int lat, r0, w0;
        r0 = rd_beats;
        do_read(10'h041, d, lat);
        chk("R1 first read from memory", d, memval('h041));
        chk("R4 fill beats", 32'(rd_beats - r0), 32'd4);
        r0 = rd_beats;
        do_read(10'h043, d, lat);
        chk("R3 hit data", d, memval('h043));
        chk("R3 hit latency", 32'(lat), 32'd1);
        chk("R3 hit no beats", 32'(rd_beats - r0), 32'd0);
        w0 = wr_beats;
        do_cmd(OP_WRITE, 10'h041, 32'h0000_1111);
        chk("R2 no write beat", 32'(wr_beats - w0), 32'd0);
        chk("R2 memory untouched", mem[10'h041], memval('h041));
        do_read(10'h041, d, lat);
        chk("R2 read back written", d, 32'h0000_1111);
    endtask

    task automatic t_partial_fill;
        logic [DW-1:0] d;
        int lat, r0;
        do_cmd(OP_WRITE, 10'h046, 32'h0000_6666);
        r0 = rd_beats;
        do_read(10'h044, d, lat);
        chk("R4 partial fill beats", 32'(rd_beats - r0), 32'd3);
        chk("R4 fill data", d, memval('h044));
        do_read(10'h046, d, lat);
        chk("R4 local word kept", d, 32'h0000_6666);
    endtask

    task automatic t_release;
        logic [DW-1:0] d;
        int lat, r0, w0;
        w0 = wr_beats;
        do_cmd(OP_RELEASE, '0, '0);
        chk("R10 busy during release", 32'(busy_after), 32'd1);
        chk("R7 release beats", 32'(wr_beats - w0), 32'd2);
        chk("R7 mem word A", mem[10'h041], 32'h0000_1111);
        chk("R7 mem word B", mem[10'h046], 32'h0000_6666);
        r0 = rd_beats;
        do_read(10'h041, d, lat);
        chk("R7 still resident", 32'(rd_beats - r0), 32'd0);
        chk("R7 resident value", d, 32'h0000_1111);
        w0 = wr_beats;
        do_cmd(OP_FLUSH, '0, '0);
        chk("R7 clean not written", 32'(wr_beats - w0), 32'd0);
        r0 = rd_beats;
        do_read(10'h041, d, lat);
        chk("R5 invalid after flush", 32'(rd_beats - r0), 32'd4);
        chk("R5 value from memory", d, 32'h0000_1111);
    endtask

    task automatic t_flush_dirty;
        int w0;
        do_cmd(OP_WRITE, 10'h042, 32'h0000_2424);
        w0 = wr_beats;
        do_cmd(OP_FLUSH, '0, '0);
        chk("R5 flush beats", 32'(wr_beats - w0), 32'd1);
        chk("R5 flushed word", mem[10'h042], 32'h0000_2424);
    endtask

    task automatic t_acquire;
        logic [DW-1:0] d;
        int lat, r0, w0;
        do_read(10'h049, d, lat);
        do_cmd(OP_WRITE, 10'h04C, 32'h0000_2222);
        r0 = rd_beats;
        w0 = wr_beats;
        do_cmd(OP_ACQUIRE, '0, '0);
        chk("R6 one cycle", 32'(busy_after), 32'd0);
        chk("R6 no traffic", 32'((rd_beats - r0) + (wr_beats - w0)), 32'd0);
        r0 = rd_beats;
        do_read(10'h049, d, lat);
        chk("R6 clean dropped", 32'(rd_beats - r0), 32'd4);
        r0 = rd_beats;
        do_read(10'h04C, d, lat);
        chk("R6 dirty kept beats", 32'(rd_beats - r0), 32'd0);
        chk("R6 dirty kept value", d, 32'h0000_2222);
        do_cmd(OP_FLUSH, '0, '0);
    endtask

    task automatic t_barrier;
        logic [DW-1:0] d;
        int lat, r0, w0;
        do_read(10'h080, d, lat);
        do_cmd(OP_WRITE, 10'h087, 32'h0000_3333);
        w0 = wr_beats;
        do_cmd(OP_BARRIER, '0, '0);
        chk("R8 barrier beats", 32'(wr_beats - w0), 32'd1);
        chk("R8 mem word", mem[10'h087], 32'h0000_3333);
        r0 = rd_beats;
        do_read(10'h080, d, lat);
        chk("R8 clean dropped", 32'(rd_beats - r0), 32'd4);
        r0 = rd_beats;
        do_read(10'h087, d, lat);
        chk("R8 dirty kept", 32'(rd_beats - r0), 32'd0);
        chk("R8 kept value", d, 32'h0000_3333);
        do_cmd(OP_FLUSH, '0, '0);
    endtask

    task automatic t_evict;
        logic [DW-1:0] d;
        int lat, r0, w0;
        do_cmd(OP_WRITE, 10'h0C8, 32'h0000_4444);
        do_cmd(OP_WRITE, 10'h0CB, 32'h0000_5555);
        r0 = rd_beats;
        w0 = wr_beats;
        do_read(10'h109, d, lat);
        chk("R9 evict beats", 32'(wr_beats - w0), 32'd2);
        chk("R9 evict word 0", mem[10'h0C8], 32'h0000_4444);
        chk("R9 evict word 3", mem[10'h0CB], 32'h0000_5555);
        chk("R9 refill beats", 32'(rd_beats - r0), 32'd4);
        chk("R9 new data", d, memval('h109));
        w0 = wr_beats;
        do_read(10'h0C8, d, lat);
        chk("R9 clean victim no beats", 32'(wr_beats - w0), 32'd0);
        chk("R9 victim data back", d, 32'h0000_4444);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_write();
        t_partial_fill();
        t_release();
        t_flush_dirty();
        t_acquire();
        t_barrier();
        t_evict();
        chk("R11 no overlapping beats", 32'(overlap), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule